// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block sits between an on-chip requester and an asynchronous fast-page-mode DRAM with a 4-bit data bus. It turns single-word read and write requests into row and column strobe sequences. The word address is split into a row part and a column part, and both are multiplexed over one set of address pins. After a row has been opened, the controller keeps it open. Later requests that fall in the same row run as short page-mode column cycles, with a CAS precharge gap between them. A request for a different row makes the controller close the current row and open the new one.

Every DRAM timing limit is a parameter counted in system clock cycles, rounded up from the nanosecond figure for the chosen clock. The controller counts how long RAS has been low. It stops taking page hits early enough that the row is always closed before the longest permitted RAS-low time is reached, even when no traffic arrives.

Refresh is generated by a separate block that raises `ref_req`. The controller completes the column cycle in progress and precharges the row. It then asserts `ref_gnt` and keeps it high until the request drops. Writes are always early writes. Reads come back as a one-cycle `rd_valid` pulse.

The request port is valid/ready. A request is taken on a clock edge where both `req_valid` and `req_ready` are high, and its address, direction and data are captured at that edge. While `req_valid` is high the requester must hold the request stable. `req_ready` may depend on the presented address: while a row is open, `req_ready` stays low for a request to another row. There is no back-pressure on read data, so `rd_valid` cannot be stalled.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: The request address is split with the row in the upper ROW_W bits and the column in the lower COL_W bits. The row is on `dram_addr` when RAS falls. The column, zero-extended, is on `dram_addr` when CAS falls.
- R2: CAS falls no sooner than T_RCD cycles after the RAS fall that opened the row.
- R3: RAS stays low at least T_RAS cycles and stays high at least T_RP cycles before the next row is opened. Two successive RAS falls are at least T_RC cycles apart.
- R4: CAS falls only while RAS is low. CAS stays low at least T_CAS cycles and high at least T_CP cycles. Two CAS falls within one open row are at least T_PC cycles apart.
- R5: RAS is never low for RASP_CYC cycles or more, including when no requests arrive after an access.
- R6: Writes are early writes. WE is low only while CAS is low, and WE falls on the same edge as CAS. Write data is driven (`dram_dq_oe`=1) during the whole CAS-low time of a write, and OE stays high during writes. During reads WE is high, OE is low and `dram_dq_oe` is 0.
- R7: For each accepted read, `rd_valid` pulses high for exactly one cycle. `rd_data` is captured on the edge where CAS rises, at which point CAS has been low at least T_CAC cycles and RAS at least T_RAC cycles. The data equals the last value written to that address.
- R8: While a row is open, `req_ready` stays low for a request to another row. That row is closed and the request is then accepted and served from the new row.
- R9: While `ref_req` is high, no new request is accepted. `ref_gnt` rises only after RAS and CAS are both high and RAS has been high at least T_RP cycles. It then stays high, with RAS and CAS high, until the cycle after `ref_req` falls.
- R10: During reset, every DRAM strobe is high (inactive), and `dram_dq_oe`, `rd_valid`, `ref_gnt` and `req_ready` are low. After reset, `req_ready` stays low until the RAS precharge time has passed.
- R11: Address, direction and write data are taken only on the accepting edge. Changing them after that edge does not affect the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | ROW_W+COL_W | Word address, row in upper bits |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DQ_W | Write data |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | DQ_W | Read data |
| ref_req | input | 1 | Refresh block asks for the DRAM |
| ref_gnt | output | 1 | DRAM is precharged and handed to the refresh block |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | ROW_W | Multiplexed row/column address |
| dram_dq_out | output | DQ_W | Data toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | DQ_W | Data from the DRAM |

## Verification
The bench builds the controller with 3 row bits and 3 column bits, so the whole 64-word array can be swept. The rounded timing values for a 125 MHz clock are kept. RASP_CYC is cut to 40 cycles, which makes a row-major sweep of a single row run into the RAS-low limit and forces closes in the middle of a row. A column-major sweep turns every access into a row miss. A bench DRAM model counts strobe intervals in whole cycles and returns the wrong data until the access times have passed, so reading too early shows up as a data mismatch.

// File: rtl/fpm_ctrl_pkg.sv
package fpm_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,  // row closed, RAS high (precharging)
    ST_RCD  = 3'd1,  // RAS low, row address on pins
    ST_CAS  = 3'd2,  // CAS low, column access in progress
    ST_CP   = 3'd3,  // CAS precharge inside an open row
    ST_OPEN = 3'd4,  // row open, waiting for a hit
    ST_REF  = 3'd5   // DRAM handed to the refresh block
  } fpm_state_e;

  function automatic int fpm_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fpm_sat_cnt.sv
module fpm_sat_cnt #(
  parameter int W          = 8,
  parameter bit START_FULL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= START_FULL ? '1 : '0;
    else if (clr)            cnt <= '0;
    else if (cnt != '1)      cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/fpm_pin_regs.sv
module fpm_pin_regs
  import fpm_ctrl_pkg::*;
#(
  parameter int ROW_W = 11,
  parameter int COL_W = 11,
  parameter int DQ_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  fpm_state_e       st_nx,
  input  logic [ROW_W-1:0] row_nx,
  input  logic [COL_W-1:0] col_nx,
  input  logic             we_nx,
  input  logic [DQ_W-1:0]  wd_nx,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic             oe_n,
  output logic [ROW_W-1:0] addr,
  output logic [DQ_W-1:0]  dq_out,
  output logic             dq_oe,
  output logic             ref_gnt
);

  logic ras_on, cas_on;

  assign ras_on = (st_nx == ST_RCD) || (st_nx == ST_CAS) ||
                  (st_nx == ST_CP)  || (st_nx == ST_OPEN);
  assign cas_on = (st_nx == ST_CAS);

  // Strobes are decoded from the next state and registered, so the pins
  // change cleanly on the same edge as the controller state.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_n   <= 1'b1;
      cas_n   <= 1'b1;
      we_n    <= 1'b1;
      oe_n    <= 1'b1;
      addr    <= '0;
      dq_out  <= '0;
      dq_oe   <= 1'b0;
      ref_gnt <= 1'b0;
    end else begin
      ras_n   <= !ras_on;
      cas_n   <= !cas_on;
      we_n    <= !(cas_on && we_nx);
      oe_n    <= !(cas_on && !we_nx);
      addr    <= (st_nx == ST_RCD) ? row_nx : ROW_W'(col_nx);
      dq_out  <= wd_nx;
      dq_oe   <= cas_on && we_nx;
      ref_gnt <= (st_nx == ST_REF);
    end
  end

endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
  import fpm_ctrl_pkg::*;
#(
  parameter int ROW_W    = 11,
  parameter int COL_W    = 11,
  parameter int DQ_W     = 4,
  parameter int T_RCD    = 3,
  parameter int T_RAS    = 7,
  parameter int T_RP     = 4,
  parameter int T_RC     = 12,
  parameter int T_CAS    = 2,
  parameter int T_CP     = 1,
  parameter int T_PC     = 5,
  parameter int T_CAC    = 2,
  parameter int T_RAC    = 7,
  parameter int T_WCH    = 1,
  parameter int RASP_CYC = 12000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic                   req_we,
  input  logic [DQ_W-1:0]        req_wdata,
  output logic                   rd_valid,
  output logic [DQ_W-1:0]        rd_data,
  input  logic                   ref_req,
  output logic                   ref_gnt,
  output logic                   dram_ras_n,
  output logic                   dram_cas_n,
  output logic                   dram_we_n,
  output logic                   dram_oe_n,
  output logic [ROW_W-1:0]       dram_addr,
  output logic [DQ_W-1:0]        dram_dq_out,
  output logic                   dram_dq_oe,
  input  logic [DQ_W-1:0]        dram_dq_in
);

  localparam int AW      = ROW_W + COL_W;
  localparam int CAS_RD  = fpm_max(T_CAS, T_CAC);
  localparam int CAS_WR  = fpm_max(T_CAS, T_WCH);
  // Longest stretch from accepting a hit until RAS can be raised again.
  localparam int ACC_MAX = T_RAC + CAS_RD + CAS_WR + T_CP + T_PC + 2;
  localparam int CW      = $clog2(RASP_CYC + T_RC + T_PC + 4) + 1;

  localparam logic [CW-1:0] C_RCD   = CW'(T_RCD - 1);
  localparam logic [CW-1:0] C_RAS   = CW'(T_RAS - 1);
  localparam logic [CW-1:0] C_RP    = CW'(T_RP - 1);
  localparam logic [CW-1:0] C_RC    = CW'(T_RC - 1);
  localparam logic [CW-1:0] C_CRD   = CW'(CAS_RD - 1);
  localparam logic [CW-1:0] C_CWR   = CW'(CAS_WR - 1);
  localparam logic [CW-1:0] C_RAC   = CW'(T_RAC - 1);
  localparam logic [CW-1:0] C_CP    = CW'(T_CP - 1);
  localparam logic [CW-1:0] C_PC    = CW'(T_PC - 1);
  localparam logic [CW-1:0] C_GUARD = CW'(RASP_CYC - ACC_MAX);

  fpm_state_e st_q, st_d;

  logic [ROW_W-1:0] op_row, row_d;
  logic [COL_W-1:0] op_col, col_d;
  logic             op_we, we_d;
  logic [DQ_W-1:0]  op_wd, wd_d;

  logic [CW-1:0] ph_cnt, ras_cnt, col_cnt;
  logic          acc, hit, guard, rp_ok, rc_ok, cas_done;

  logic [ROW_W-1:0] req_row;
  logic [COL_W-1:0] req_col;

  assign req_row = req_addr[AW-1:COL_W];
  assign req_col = req_addr[COL_W-1:0];
  assign hit     = (req_row == op_row);
  assign guard   = (ras_cnt >= C_GUARD);
  assign rp_ok   = (ph_cnt >= C_RP);
  assign rc_ok   = (ras_cnt >= C_RC);

  // Cycles in the current state, cycles since RAS fell, cycles since CAS fell.
  fpm_sat_cnt #(.W(CW), .START_FULL(1'b0)) u_ph_cnt (
    .clk(clk), .rst_n(rst_n), .clr(st_d != st_q), .cnt(ph_cnt));

  fpm_sat_cnt #(.W(CW), .START_FULL(1'b1)) u_ras_cnt (
    .clk(clk), .rst_n(rst_n), .clr((st_q == ST_IDLE) && (st_d == ST_RCD)),
    .cnt(ras_cnt));

  fpm_sat_cnt #(.W(CW), .START_FULL(1'b1)) u_col_cnt (
    .clk(clk), .rst_n(rst_n), .clr((st_d == ST_CAS) && (st_q != ST_CAS)),
    .cnt(col_cnt));

  always_comb begin
    cas_done = 1'b0;
    if (st_q == ST_CAS) begin
      if (op_we) cas_done = (ph_cnt >= C_CWR);
      else       cas_done = (ph_cnt >= C_CRD) && (ras_cnt >= C_RAC);
    end
  end

  always_comb begin
    st_d      = st_q;
    acc       = 1'b0;
    req_ready = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        req_ready = rp_ok && rc_ok && !ref_req;
        if (rp_ok && ref_req) begin
          st_d = ST_REF;
        end else if (req_ready && req_valid) begin
          st_d = ST_RCD;
          acc  = 1'b1;
        end
      end
      ST_RCD:  if (ph_cnt >= C_RCD) st_d = ST_CAS;
      ST_CAS:  if (cas_done) st_d = ST_CP;
      ST_CP:   if ((ph_cnt >= C_CP) && (col_cnt >= C_PC)) st_d = ST_OPEN;
      ST_OPEN: begin
        req_ready = !ref_req && !guard && hit;
        if (req_valid && req_ready) begin
          st_d = ST_CAS;
          acc  = 1'b1;
        end else if ((ref_req || guard || req_valid) && (ras_cnt >= C_RAS)) begin
          st_d = ST_IDLE;
        end
      end
      ST_REF:  if (!ref_req) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign row_d = (acc && (st_q == ST_IDLE)) ? req_row : op_row;
  assign col_d = acc ? req_col   : op_col;
  assign we_d  = acc ? req_we    : op_we;
  assign wd_d  = acc ? req_wdata : op_wd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      op_row   <= '0;
      op_col   <= '0;
      op_we    <= 1'b0;
      op_wd    <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      st_q     <= st_d;
      op_row   <= row_d;
      op_col   <= col_d;
      op_we    <= we_d;
      op_wd    <= wd_d;
      rd_valid <= cas_done && !op_we;
      if (cas_done && !op_we) rd_data <= dram_dq_in;
    end
  end

  fpm_pin_regs #(.ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W)) u_pins (
    .clk(clk), .rst_n(rst_n), .st_nx(st_d), .row_nx(row_d), .col_nx(col_d),
    .we_nx(we_d), .wd_nx(wd_d),
    .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n), .oe_n(dram_oe_n),
    .addr(dram_addr), .dq_out(dram_dq_out), .dq_oe(dram_dq_oe), .ref_gnt(ref_gnt));

  // R2: column strobe never falls before the row-to-column delay has passed
  assert_rcd_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_cas_n) |-> (ras_cnt >= CW'(T_RCD)));

  // R3: a row stays open at least the minimum RAS-low time
  assert_ras_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_ras_n) |-> (ras_cnt >= CW'(T_RAS)));

  // R5: RAS-low time stays below the page-mode limit
  assert_ras_max_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_ras_n |-> (ras_cnt < CW'(RASP_CYC)));

  // R7: read data is reported on the edge where the column strobe ends
  assert_rd_at_cas_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $rose(dram_cas_n));

  // R9: the refresh grant only ever sees a fully precharged DRAM
  assert_gnt_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_gnt |-> (dram_ras_n && dram_cas_n && $past(ref_req)));

endmodule

// File: tb/fpm_dram_ctrl_bench.sv
`timescale 1ns/1ps
module fpm_dram_ctrl_bench;

  localparam int RW = 3, CLW = 3, DW = 4, AWD = RW + CLW, NW = 1 << AWD;
  localparam int T_RCD = 3, T_RAS = 7, T_RP = 4, T_RC = 12, T_CAS = 2;
  localparam int T_CP = 1, T_PC = 5, T_CAC = 2, T_RAC = 7, T_WCH = 1;
  localparam int RASP = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, ref_req = 1'b0;
  logic [AWD-1:0] req_addr = '0;
  logic [DW-1:0]  req_wdata = '0, dram_dq_in = '0;
  logic req_ready, rd_valid, ref_gnt, dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [DW-1:0] rd_data, dram_dq_out;
  logic [RW-1:0] dram_addr;

  always #4 clk = ~clk;

  fpm_dram_ctrl #(.ROW_W(RW), .COL_W(CLW), .DQ_W(DW), .T_RCD(T_RCD), .T_RAS(T_RAS),
    .T_RP(T_RP), .T_RC(T_RC), .T_CAS(T_CAS), .T_CP(T_CP), .T_PC(T_PC), .T_CAC(T_CAC),
    .T_RAC(T_RAC), .T_WCH(T_WCH), .RASP_CYC(RASP)) u_fpm_dram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .ref_req(ref_req), .ref_gnt(ref_gnt), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
    .dram_addr(dram_addr), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
    .dram_dq_in(dram_dq_in));

  int n_chk = 0, n_err = 0, la = -1;
  bit done = 0;
  logic [DW-1:0] sh [NW];
  logic [DW-1:0] exp_q [$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- DRAM model: counts strobe intervals at each falling clock edge
  logic [DW-1:0] mem [NW];
  logic [RW-1:0] m_row = '0;
  logic [CLW-1:0] m_col = '0;
  int ras_lc = 0, ras_hc = 0, cas_lc = 0, cas_hc = 100, since_rf = 100, since_cf = 100;
  bit ras_p = 1, cas_p = 1, gnt_p = 0, cf_valid = 0;

  always @(negedge clk) begin
    since_rf++;
    since_cf++;
    if (dram_ras_n) begin
      ras_hc++;
      if (!ras_p) begin
        chk(ras_lc >= T_RAS, "R3 ras low width", ras_lc, T_RAS);
        chk(ras_lc <= RASP, "R5 ras low limit", ras_lc, RASP);
      end
    end else begin
      if (ras_p) begin
        chk(ras_hc >= T_RP, "R3 ras precharge", ras_hc, T_RP);
        chk(since_rf >= T_RC, "R3 ras cycle", since_rf, T_RC);
        m_row = dram_addr; ras_lc = 0; since_rf = 0; cf_valid = 0;
      end
      ras_lc++;
      ras_hc = 0;
    end
    if (dram_cas_n) begin
      cas_hc++;
      if (!cas_p) chk(cas_lc >= T_CAS, "R4 cas low width", cas_lc, T_CAS);
    end else begin
      if (cas_p) begin
        chk(!dram_ras_n, "R4 cas under ras", dram_ras_n, 0);
        chk(ras_lc - 1 >= T_RCD, "R2 ras to cas", ras_lc - 1, T_RCD);
        chk(cas_hc >= T_CP, "R4 cas precharge", cas_hc, T_CP);
        if (cf_valid) chk(since_cf >= T_PC, "R4 page period", since_cf, T_PC);
        cf_valid = 1; since_cf = 0; cas_lc = 0;
        m_col = dram_addr[CLW-1:0];
        chk(dram_addr[RW-1:CLW] == '0 || RW == CLW, "R1 column zero-extended", dram_addr, m_col);
        chk(int'({m_row, m_col}) == la, "R1 row/column on pins", {m_row, m_col}, la);
        if (!dram_we_n) begin
          chk(dram_dq_oe && dram_oe_n, "R6 write strobes", {dram_dq_oe, dram_oe_n}, 3);
          mem[{m_row, m_col}] = dram_dq_out;
        end else begin
          chk(!dram_oe_n && !dram_dq_oe, "R6 read strobes", {dram_oe_n, dram_dq_oe}, 0);
        end
      end
      cas_lc++;
      cas_hc = 0;
    end
    if (!dram_we_n && dram_cas_n) chk(0, "R6 we without cas", 1, 0);
    if (dram_dq_oe && dram_we_n) chk(0, "R6 data driven outside write", 1, 0);
    if (!dram_we_n && !dram_cas_n && !dram_dq_oe) chk(0, "R6 write data not driven", 0, 1);
    if (ref_gnt && !gnt_p)
      chk(dram_ras_n && dram_cas_n && ras_hc >= T_RP, "R9 grant after precharge", ras_hc, T_RP);
    if (ref_gnt && (!dram_ras_n || !dram_cas_n)) chk(0, "R9 strobes during grant", 0, 1);
    ras_p = dram_ras_n; cas_p = dram_cas_n; gnt_p = ref_gnt;
    // wrong data until both access times have elapsed
    if (!dram_ras_n && !dram_cas_n && !dram_oe_n && cas_lc >= T_CAC && ras_lc >= T_RAC)
      dram_dq_in <= mem[{m_row, m_col}];
    else
      dram_dq_in <= ~mem[{m_row, m_col}];
  end

  // ---------------- read-data monitor
  bit rdv_p = 0;
  always @(negedge clk) begin
    if (rd_valid && rdv_p) chk(0, "R7 rd_valid longer than one cycle", 2, 1);
    if (rd_valid) begin
      if (exp_q.size() == 0) chk(0, "R7 unexpected read data", rd_data, -1);
      else chk(rd_data == exp_q.pop_front(), "R7/R11 read data", rd_data, -1);
    end
    rdv_p = rd_valid;
  end

  // ---------------- host side
  task automatic accept();
    forever begin
      #1;
      if (!dram_ras_n && req_addr[AWD-1:CLW] != m_row)
        chk(!req_ready, "R8 no ready on row miss", req_ready, 0);
      if (req_ready) break;
      @(negedge clk);
    end
    @(posedge clk);
    la = int'(req_addr);
    if (req_we) sh[req_addr] = req_wdata;
    else exp_q.push_back(sh[req_addr]);
    #1;
    req_valid = 0;
    req_addr  = ~req_addr;   // R11: later changes must not reach the access
    req_wdata = ~req_wdata;
    req_we    = ~req_we;
  endtask

  task automatic req(input int a, input bit w, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1; req_addr = AWD'(a); req_we = w; req_wdata = d;
    accept();
  endtask

  task automatic drain();
    for (int i = 0; i < 60 && exp_q.size() != 0; i++) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all reads returned", exp_q.size(), 0);
  endtask

  initial begin
    for (int i = 0; i < NW; i++) begin mem[i] = '0; sh[i] = '0; end
    repeat (3) @(negedge clk);
    #1;
    chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n && !dram_dq_oe &&
        !rd_valid && !ref_gnt && !req_ready, "R10 reset state", 0, 0);
    rst_n = 1;
    req_valid = 1; req_addr = '0; req_we = 1; req_wdata = 4'h3;
    @(negedge clk); #1;
    chk(!req_ready, "R10 ready held through precharge", req_ready, 0);
    req_valid = 0;

    // Row-major write sweep: page hits, with closes forced by the RAS limit (R5)
    for (int a = 0; a < NW; a++) req(a, 1, DW'(a * 5 + 3));
    for (int a = 0; a < NW; a++) req(a, 0, '0);
    drain();

    // Column-major sweep: every access misses the open row (R8)
    for (int c = 0; c < (1 << CLW); c++)
      for (int r = 0; r < (1 << RW); r++) req(r * 8 + c, 1, DW'((r * 8 + c) ^ 9));
    for (int i = NW - 1; i >= 0; i--) req((i % 8) * 8 + i / 8, 0, '0);
    drain();

    // Interleaved write/read with stride 9
    for (int i = 0; i < 16; i++) begin
      req((i * 9) % NW, 1, DW'(i + 6));
      req((i * 9) % NW, 0, '0);
      req((i * 9 + 1) % NW, 0, '0);
    end
    drain();

    // Refresh while a row is open and a hit is waiting (R9)
    req(8 + 1, 0, '0);
    drain();
    @(negedge clk);
    ref_req = 1; req_valid = 1; req_addr = 8 + 2; req_we = 0;
    begin
      bit seen = 0, took = 0;
      for (int i = 0; i < 60; i++) begin
        #1;
        if (req_ready) took = 1;
        if (ref_gnt) begin seen = 1; break; end
        @(negedge clk);
      end
      chk(seen, "R9 grant given", seen, 1);
      chk(!took, "R9 no accept while refresh pending", took, 0);
      for (int i = 0; i < 6; i++) begin
        @(negedge clk); #1;
        chk(ref_gnt && !req_ready && dram_ras_n && dram_cas_n, "R9 grant held", ref_gnt, 1);
      end
    end
    ref_req = 0;
    @(negedge clk); #1;
    chk(!ref_gnt, "R9 grant released", ref_gnt, 0);
    accept();
    drain();

    // Open a row and leave it idle: it must close before the limit (R5)
    req(5 * 8, 0, '0);
    repeat (RASP + 10) @(negedge clk);
    chk(dram_ras_n, "R5 idle row closed by limit", dram_ras_n, 1);
    drain();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule